// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Shift and Skip

This block executes register-to-register arithmetic instructions against four accumulators and a single carry flag. Each instruction takes one clock. In that clock it reads a source and a destination accumulator and applies one of eight ALU functions. It then forms a carry result from a selectable base carry. The result passes through an optional rotate-through-carry or byte exchange. The unit can write the result back, and it always reports whether the following instruction should be skipped. The result can also be discarded while the skip decision is still made, so an instruction can act as a pure test.

The unit decodes the full 16-bit instruction word itself. Words that do not belong to the arithmetic group are ignored. A separate preload port sets an accumulator and the carry directly, so surrounding logic can supply operands. The skip decision is registered and comes with a valid strobe one clock after the instruction is accepted.

Top module: `acc_alu_unit`

## Requirements
- R1: An instruction word is executed only when `op_valid` is high, `pre_en` is low and bit 15 of the word is 1. Any other word leaves the accumulators and carry unchanged and keeps `skip_vld_o` low in the next cycle.
- R2: The function field is bits 10:8, and its codes give the following results. Code 0 gives NOT src. Code 1 gives the two's complement of src. Code 2 gives src+1 and code 3 gives src. Code 4 gives dst+src. Code 5 gives dst+NOT src+1 and code 6 gives dst+NOT src. Code 7 gives dst AND src. Src is selected by bits 14:13 and dst by bits 12:11.
- R3: Bits 5:4 select the base carry: 0 is the current carry, 1 is zero, 2 is one, and 3 is the inverted current carry. The carry result is the base carry XOR the carry-out of the 17-bit sum. Codes 0, 3 and 7 have a carry-out of 0.
- R4: Bits 7:6 select the shift. Code 0 is no shift. Code 1 rotates the 17-bit value {carry result, result} left by one. Code 2 rotates it right by one. Code 3 exchanges the two bytes of the result and keeps the carry result.
- R5: Bits 2:0 select the skip test on the shifted result and the final carry. The codes, from 0 to 7, are: never; always; carry is 0; carry is not 0; result is 0; result is not 0; result is 0 or carry is 0; result is not 0 and carry is not 0.
- R6: When bit 3 is 1, neither the destination accumulator nor the carry changes, but the skip outcome is still reported.
- R7: When `pre_en` is high, accumulator `pre_sel` takes `pre_data` and the carry takes `pre_carry` at the clock edge. Any instruction presented in the same cycle is ignored.
- R8: After reset, all accumulators, the carry, `skip_o` and `skip_vld_o` are 0.
- R9: The write-back, the new carry, `skip_o` and a high `skip_vld_o` all appear one clock after the instruction is accepted. `skip_o` is never high while `skip_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Instruction word present this cycle |
| op_word | input | 16 | Instruction word |
| pre_en | input | 1 | Preload strobe |
| pre_sel | input | 2 | Accumulator to preload |
| pre_data | input | W | Preload value |
| pre_carry | input | 1 | Carry value written with a preload |
| acc_o | output | 4*W | Accumulators, accumulator 0 in the low bits |
| carry_o | output | 1 | Carry flag |
| skip_o | output | 1 | Skip decision of the last executed instruction |
| skip_vld_o | output | 1 | Skip decision valid this cycle |

## Verification
The bench steps through every combination of the fifteen field bits exactly once. This pairs each function with each carry base, shift, skip test and no-load setting. Between groups of instructions, operands are reloaded from a mix of random values and the edge values 0, 0x0001, 0x8000 and 0xFFFF. These edge values are what separate the carry-out cases: increment of all ones, negation of zero, and borrow or no borrow in subtraction. They also make the zero-result skip tests actually fire. Results are chained from one instruction to the next, so an accumulator or carry write that went astray shows up later even when the instruction that caused it skipped its own check. Words outside the group and preloads that collide with an instruction are also presented, to show they leave no trace.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int ACC_N = 4;
  localparam int SEL_W = 2;
  localparam int OP_W  = 16;

  typedef enum logic [2:0] {
    FN_NOT = 3'd0, FN_NEG = 3'd1, FN_INC = 3'd2, FN_MOV = 3'd3,
    FN_ADD = 3'd4, FN_SUB = 3'd5, FN_SBC = 3'd6, FN_AND = 3'd7
  } fn_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0, SH_ROL = 2'd1, SH_ROR = 2'd2, SH_SWAP = 2'd3
  } sh_e;

  typedef enum logic [1:0] {
    CB_KEEP = 2'd0, CB_ZERO = 2'd1, CB_ONE = 2'd2, CB_FLIP = 2'd3
  } cb_e;

  typedef enum logic [2:0] {
    SK_NEVER = 3'd0, SK_ALWAYS = 3'd1, SK_CZ = 3'd2, SK_CNZ = 3'd3,
    SK_RZ = 3'd4, SK_RNZ = 3'd5, SK_RZ_OR_CZ = 3'd6, SK_RNZ_AND_CNZ = 3'd7
  } sk_e;

  typedef struct packed {
    logic             grp;
    logic [SEL_W-1:0] src;
    logic [SEL_W-1:0] dst;
    fn_e              fn;
    sh_e              sh;
    cb_e              cb;
    logic             nold;
    sk_e              sk;
  } op_t;

endpackage

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] src_val,
  input  logic [W-1:0] dst_val,
  input  fn_e          fn,
  input  cb_e          cb,
  input  logic         carry_in,
  output logic [W-1:0] res,
  output logic         c_res
);

  localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

  logic [W:0] sum;
  logic       base;

  always_comb begin
    unique case (fn)
      FN_NOT:  sum = {1'b0, ~src_val};
      FN_NEG:  sum = {1'b0, ~src_val} + ONE;
      FN_INC:  sum = {1'b0, src_val} + ONE;
      FN_MOV:  sum = {1'b0, src_val};
      FN_ADD:  sum = {1'b0, dst_val} + {1'b0, src_val};
      FN_SUB:  sum = {1'b0, dst_val} + {1'b0, ~src_val} + ONE;
      FN_SBC:  sum = {1'b0, dst_val} + {1'b0, ~src_val};
      default: sum = {1'b0, dst_val & src_val};
    endcase
  end

  always_comb begin
    unique case (cb)
      CB_KEEP: base = carry_in;
      CB_ZERO: base = 1'b0;
      CB_ONE:  base = 1'b1;
      default: base = ~carry_in;
    endcase
  end

  assign res   = sum[W-1:0];
  assign c_res = base ^ sum[W];

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] in_val,
  input  logic         in_c,
  input  sh_e          sh,
  output logic [W-1:0] out_val,
  output logic         out_c
);

  localparam int HALF = W / 2;

  always_comb begin
    unique case (sh)
      SH_ROL: begin
        out_val = {in_val[W-2:0], in_c};
        out_c   = in_val[W-1];
      end
      SH_ROR: begin
        out_val = {in_c, in_val[W-1:1]};
        out_c   = in_val[0];
      end
      SH_SWAP: begin
        out_val = {in_val[HALF-1:0], in_val[W-1:HALF]};
        out_c   = in_c;
      end
      default: begin
        out_val = in_val;
        out_c   = in_c;
      end
    endcase
  end

endmodule

// File: rtl/acc_alu_skip.sv
module acc_alu_skip
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         c,
  input  sk_e          sk,
  output logic         take
);

  logic rz;
  logic cz;

  assign rz = (val == '0);
  assign cz = ~c;

  always_comb begin
    unique case (sk)
      SK_NEVER:       take = 1'b0;
      SK_ALWAYS:      take = 1'b1;
      SK_CZ:          take = cz;
      SK_CNZ:         take = ~cz;
      SK_RZ:          take = rz;
      SK_RNZ:         take = ~rz;
      SK_RZ_OR_CZ:    take = rz | cz;
      default:        take = ~rz & ~cz;
    endcase
  end

endmodule

// File: rtl/acc_alu_regs.sv
module acc_alu_regs
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pre_en,
  input  logic [SEL_W-1:0]   pre_sel,
  input  logic [W-1:0]       pre_data,
  input  logic               pre_carry,
  input  logic               ex_en,
  input  logic               ex_wr,
  input  logic [SEL_W-1:0]   ex_sel,
  input  logic [W-1:0]       ex_data,
  input  logic               ex_carry,
  input  logic               ex_skip,
  output logic [ACC_N*W-1:0] acc_flat,
  output logic               carry_q,
  output logic               skip_q,
  output logic               skip_vld_q
);

  logic [W-1:0] acc_q [ACC_N];
  logic [W-1:0] acc_d [ACC_N];
  logic         carry_d;
  logic         skip_d;
  logic         skip_vld_d;

  always_comb begin
    for (int i = 0; i < ACC_N; i++) begin
      acc_d[i] = acc_q[i];
    end
    carry_d    = carry_q;
    skip_d     = 1'b0;
    skip_vld_d = 1'b0;
    if (pre_en) begin
      acc_d[pre_sel] = pre_data;
      carry_d        = pre_carry;
    end else if (ex_en) begin
      skip_d     = ex_skip;
      skip_vld_d = 1'b1;
      if (ex_wr) begin
        acc_d[ex_sel] = ex_data;
        carry_d       = ex_carry;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ACC_N; i++) begin
        acc_q[i] <= '0;
      end
      carry_q    <= 1'b0;
      skip_q     <= 1'b0;
      skip_vld_q <= 1'b0;
    end else begin
      for (int i = 0; i < ACC_N; i++) begin
        acc_q[i] <= acc_d[i];
      end
      carry_q    <= carry_d;
      skip_q     <= skip_d;
      skip_vld_q <= skip_vld_d;
    end
  end

  for (genvar g = 0; g < ACC_N; g++) begin : g_flat
    assign acc_flat[g*W +: W] = acc_q[g];
  end

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [OP_W-1:0]    op_word,
  input  logic               pre_en,
  input  logic [SEL_W-1:0]   pre_sel,
  input  logic [W-1:0]       pre_data,
  input  logic               pre_carry,
  output logic [ACC_N*W-1:0] acc_o,
  output logic               carry_o,
  output logic               skip_o,
  output logic               skip_vld_o
);

  op_t          op;
  logic         exec_en;
  logic [W-1:0] src_val;
  logic [W-1:0] dst_val;
  logic [W-1:0] alu_res;
  logic         alu_c;
  logic [W-1:0] sh_res;
  logic         sh_c;
  logic         skip_take;

  assign op      = op_t'(op_word);
  assign exec_en = op_valid & op.grp;
  assign src_val = acc_o[op.src*W +: W];
  assign dst_val = acc_o[op.dst*W +: W];

  acc_alu_exec #(.W(W)) u_exec (
    .src_val  (src_val),
    .dst_val  (dst_val),
    .fn       (op.fn),
    .cb       (op.cb),
    .carry_in (carry_o),
    .res      (alu_res),
    .c_res    (alu_c)
  );

  acc_alu_shift #(.W(W)) u_shift (
    .in_val  (alu_res),
    .in_c    (alu_c),
    .sh      (op.sh),
    .out_val (sh_res),
    .out_c   (sh_c)
  );

  acc_alu_skip #(.W(W)) u_skip (
    .val  (sh_res),
    .c    (sh_c),
    .sk   (op.sk),
    .take (skip_take)
  );

  acc_alu_regs #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .pre_en     (pre_en),
    .pre_sel    (pre_sel),
    .pre_data   (pre_data),
    .pre_carry  (pre_carry),
    .ex_en      (exec_en),
    .ex_wr      (~op.nold),
    .ex_sel     (op.dst),
    .ex_data    (sh_res),
    .ex_carry   (sh_c),
    .ex_skip    (skip_take),
    .acc_flat   (acc_o),
    .carry_q    (carry_o),
    .skip_q     (skip_o),
    .skip_vld_q (skip_vld_o)
  );

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic [OP_W-1:0]    op_word,
  input logic               pre_en,
  input logic [SEL_W-1:0]   pre_sel,
  input logic [W-1:0]       pre_data,
  input logic               pre_carry,
  input logic [ACC_N*W-1:0] acc_o,
  input logic               carry_o,
  input logic               skip_o,
  input logic               skip_vld_o
);

  logic taken;
  assign taken = op_valid & op_word[15] & ~pre_en;

  a_r1_foreign_word_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_word[15] && !pre_en) |=> ($stable(acc_o) && $stable(carry_o) && !skip_vld_o));

  a_r6_noload_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && op_word[3]) |=> ($stable(acc_o) && $stable(carry_o) && skip_vld_o));

  a_r5_never_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && op_word[2:0] == 3'd0) |=> !skip_o);

  a_r5_always_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && op_word[2:0] == 3'd1) |=> skip_o);

  a_r5_carry_zero_test: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !op_word[3] && op_word[2:0] == 3'd2) |=> (skip_o == !carry_o));

  a_r7_preload_carry: assert property (@(posedge clk) disable iff (!rst_n)
    pre_en |=> (carry_o == $past(pre_carry) && !skip_vld_o));

  a_r9_skip_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_vld_o |-> !skip_o);

endmodule

bind acc_alu_unit acc_alu_chk #(.W(W)) u_chk (.*);

// File: tb/sim_acc_alu_unit.sv
module sim_acc_alu_unit;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [15:0] op_word;
  logic        pre_en;
  logic [1:0]  pre_sel;
  logic [15:0] pre_data;
  logic        pre_carry;
  logic [63:0] acc_o;
  logic        carry_o;
  logic        skip_o;
  logic        skip_vld_o;

  int n_vec;
  int n_bad;
  bit done;

  logic [15:0] m_acc [4];
  logic        m_c;

  acc_alu_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
    .pre_en(pre_en), .pre_sel(pre_sel), .pre_data(pre_data), .pre_carry(pre_carry),
    .acc_o(acc_o), .carry_o(carry_o), .skip_o(skip_o), .skip_vld_o(skip_vld_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] model_flat();
    return {m_acc[3], m_acc[2], m_acc[1], m_acc[0]};
  endfunction

  // returns {skip, carry, result}
  function automatic logic [17:0] ref_op(input logic [15:0] a, input logic [15:0] d,
                                         input logic c, input logic [15:0] w);
    logic [16:0] s;
    logic        b, cr, cf, sk;
    logic [15:0] r;
    case (w[10:8])
      3'd0: s = {1'b0, ~a};
      3'd1: s = 17'd65536 - {1'b0, a};
      3'd2: s = {1'b0, a} + 17'd1;
      3'd3: s = {1'b0, a};
      3'd4: s = {1'b0, d} + {1'b0, a};
      3'd5: s = {1'b0, d} + {1'b0, ~a} + 17'd1;
      3'd6: s = {1'b0, d} + {1'b0, ~a};
      default: s = {1'b0, d & a};
    endcase
    if (w[10:8] == 3'd1) s[16] = (a == 16'd0);
    case (w[5:4])
      2'd0: b = c;
      2'd1: b = 1'b0;
      2'd2: b = 1'b1;
      default: b = !c;
    endcase
    cr = b ^ s[16];
    case (w[7:6])
      2'd1: begin r = {s[14:0], cr}; cf = s[15]; end
      2'd2: begin r = {cr, s[15:1]}; cf = s[0]; end
      2'd3: begin r = {s[7:0], s[15:8]}; cf = cr; end
      default: begin r = s[15:0]; cf = cr; end
    endcase
    case (w[2:0])
      3'd0: sk = 1'b0;
      3'd1: sk = 1'b1;
      3'd2: sk = !cf;
      3'd3: sk = cf;
      3'd4: sk = (r == 16'd0);
      3'd5: sk = (r != 16'd0);
      3'd6: sk = (r == 16'd0) || !cf;
      default: sk = (r != 16'd0) && cf;
    endcase
    return {sk, cf, r};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 7)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic preload(input logic [1:0] sel, input logic [15:0] v, input logic c);
    @(negedge clk);
    pre_en = 1'b1; pre_sel = sel; pre_data = v; pre_carry = c;
    op_valid = 1'b0;
    @(posedge clk); #1;
    pre_en = 1'b0;
    m_acc[sel] = v; m_c = c;
  endtask

  task automatic exec(input logic [15:0] w);
    logic [17:0] e;
    e = ref_op(m_acc[w[14:13]], m_acc[w[12:11]], m_c, w);
    @(negedge clk);
    op_valid = 1'b1; op_word = w;
    @(posedge clk); #1;
    op_valid = 1'b0;
    if (!w[3]) begin
      m_acc[w[12:11]] = e[15:0];
      m_c = e[16];
    end
    if (w[3])
      check(acc_o == model_flat() && carry_o == m_c, "R6 no-load state", {acc_o[62:0], carry_o}, {model_flat()[62:0], m_c});
    else begin
      check(acc_o == model_flat(), "R2 R4 accumulators", acc_o, model_flat());
      check(carry_o == m_c, "R3 R4 carry", 64'(carry_o), 64'(m_c));
    end
    check(skip_vld_o == 1'b1 && skip_o == e[17], "R5 R9 skip", {skip_vld_o, skip_o}, {1'b1, e[17]});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    logic        snap_c;
    void'($urandom(32'd20240611));
    n_vec = 0; n_bad = 0; done = 1'b0;
    op_valid = 1'b0; op_word = '0; pre_en = 1'b0; pre_sel = '0; pre_data = '0; pre_carry = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(acc_o == 64'd0 && carry_o == 1'b0 && skip_o == 1'b0 && skip_vld_o == 1'b0,
          "R8 reset state", {acc_o[59:0], carry_o, skip_o, skip_vld_o, 1'b0}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) m_acc[i] = '0;
    m_c = 1'b0;

    // R7 preload then read back
    for (int i = 0; i < 4; i++) preload(2'(i), pick(), 1'(i));
    check(acc_o == model_flat() && carry_o == m_c, "R7 preload", acc_o, model_flat());

    // directed corners: increment of all ones, negate of zero, subtract equal
    preload(2'd0, 16'hFFFF, 1'b0);
    exec({1'b1, 2'd0, 2'd1, 3'd2, 2'd0, 2'd0, 1'b0, 3'd2}); // R3 carry out from inc
    preload(2'd2, 16'h0000, 1'b0);
    exec({1'b1, 2'd2, 2'd3, 3'd1, 2'd0, 2'd0, 1'b0, 3'd4}); // R2 negate zero
    preload(2'd1, 16'h1234, 1'b0);
    exec({1'b1, 2'd1, 2'd1, 3'd5, 2'd0, 2'd1, 1'b0, 3'd6}); // R5 result zero
    exec({1'b1, 2'd0, 2'd2, 3'd3, 2'd3, 2'd0, 1'b0, 3'd5}); // R4 byte swap

    // R1 foreign words leave no trace
    for (int i = 0; i < 20; i++) begin
      snap = acc_o; snap_c = carry_o;
      @(negedge clk);
      op_valid = 1'b1; op_word = {1'b0, 15'($urandom)};
      @(posedge clk); #1;
      op_valid = 1'b0;
      check(acc_o == snap && carry_o == snap_c && !skip_vld_o, "R1 foreign word", acc_o, snap);
    end

    // R7 preload beats a simultaneous instruction
    @(negedge clk);
    pre_en = 1'b1; pre_sel = 2'd3; pre_data = 16'hA5C3; pre_carry = 1'b1;
    op_valid = 1'b1; op_word = {1'b1, 2'd3, 2'd0, 3'd0, 2'd0, 2'd0, 1'b0, 3'd1};
    @(posedge clk); #1;
    pre_en = 1'b0; op_valid = 1'b0;
    m_acc[3] = 16'hA5C3; m_c = 1'b1;
    check(acc_o == model_flat() && carry_o && !skip_vld_o, "R7 preload priority", acc_o, model_flat());

    // every field combination once, operands refreshed every 8 instructions
    for (int k = 0; k < 32768; k++) begin
      if (k % 8 == 0) begin
        for (int i = 0; i < 4; i++) preload(2'(i), pick(), 1'($urandom));
      end
      exec({1'b1, 15'(k)});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule